// File: doc/BRIEF.md
# Bus Slave Read/Write Handshake Sequencer

This block is the control sequencer between a parallel system bus and a local device with its data transceiver. The bus master raises one of two strobes, read or write. The block then runs two interlocked four-phase handshakes. One runs toward the device: request, acknowledge, and back to zero. The other runs toward the bus: acknowledge, strobe release, and acknowledge release. The block also enables the data transceiver at the point in each cycle where the data is valid.

Reads and writes order their events differently. In a read, the device is requested first and the transceiver opens only after the device answers. In a write, the transceiver opens first and closes as soon as the device has taken the data. The device return-to-zero runs in parallel with the bus-side release. The block starts a new cycle only after both have finished.

All three inputs are asynchronous and pass through two-flop synchronizers. All outputs come directly from flops. A sticky error flag reports two faults: both strobes high at once, or a device that does not answer within a parameterised number of cycles. Neither fault changes the state sequence.

Top module: `bus_slave_hsk`

## Requirements
- R1: After reset, `dev_req`, `xcvr_en`, `bus_ack` and `proto_err` are all 0.
- R2: Read cycle. A `rd_stb` rise makes `dev_req` rise. A seen `dev_ack` rise then makes `xcvr_en` rise, and `bus_ack` rises one cycle later. A seen `rd_stb` fall makes `xcvr_en` fall, and one cycle later `bus_ack` and `dev_req` fall in the same cycle.
- R3: Write cycle. A `wr_stb` rise makes `xcvr_en` rise, and `dev_req` rises one cycle later. A seen `dev_ack` rise makes `xcvr_en` fall. One cycle later `bus_ack` rises and `dev_req` falls together. A seen `wr_stb` fall then makes `bus_ack` fall.
- R4: Every input passes through two synchronizer flops. An output that reacts to an input change does so on the third rising clock edge after the change, and not before.
- R5: A new strobe is not accepted while the synchronized `dev_ack` is still high from the previous cycle. The strobe is accepted three edges after `dev_ack` falls.
- R6: If both strobes are high while idle, no output rises and `proto_err` goes to 1. It stays 1 until reset.
- R7: If `dev_ack` differs from `dev_req` for `TIMEOUT_CYC` consecutive cycles, `proto_err` goes to 1. A late acknowledge then still advances the sequence normally. `TIMEOUT_CYC` = 0 turns the check off.
- R8: In a read, `bus_ack` falls without waiting for `dev_ack` to return low. The bus-side release does not depend on the device-side release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Bus read strobe (asynchronous) |
| wr_stb | input | 1 | Bus write strobe (asynchronous) |
| dev_ack | input | 1 | Device acknowledge (asynchronous) |
| dev_req | output | 1 | Device request strobe |
| xcvr_en | output | 1 | Data transceiver enable |
| bus_ack | output | 1 | Bus acknowledge |
| proto_err | output | 1 | Sticky protocol / timeout error |

## Verification
A sequencer stuck in the wrong state shows at the ports within one handshake step. An output rises in the wrong order, for example the transceiver opening before the device answers in a read. Or an output fails to follow its trigger on the third edge after that trigger. The bench drives each input change by hand and samples the outputs at exact edge counts. A wrong branch, a missing synchronizer stage or an early release therefore shows up as a mismatch at a specific cycle. A device-side release that is not gated shows up as a new request while the device still acknowledges.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_R_REQ   = 4'd1,
        ST_R_DATA  = 4'd2,
        ST_R_ACK   = 4'd3,
        ST_R_REL   = 4'd4,
        ST_W_EN    = 4'd5,
        ST_W_REQ   = 4'd6,
        ST_W_DROP  = 4'd7,
        ST_W_ACK   = 4'd8
    } hsk_state_e;

    typedef struct packed {
        hsk_state_e state;
        logic       dev_req;
        logic       xcvr_en;
        logic       bus_ack;
        logic       err;
    } hsk_regs_t;

    localparam hsk_regs_t HSK_RESET = '{
        state:   ST_IDLE,
        dev_req: 1'b0,
        xcvr_en: 1'b0,
        bus_ack: 1'b0,
        err:     1'b0
    };

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hsk_tmo.sv
module hsk_tmo #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    output logic expire_o
);
    generate
        if (LIMIT == 0) begin : g_off
            logic unused_ok;
            assign unused_ok = clk ^ rst_n ^ wait_i;
            assign expire_o  = 1'b0;
        end else begin : g_on
            localparam int unsigned CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!wait_i) begin
                    cnt_d = '0;
                end else if (cnt_q != LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign expire_o = wait_i && (cnt_q == LAST);

            AST_TMO_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wait_i) |-> (cnt_q == '0)); // R7
        end
    endgenerate

endmodule

// File: rtl/hsk_seq.sv
module hsk_seq
    import hsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    input  logic tmo_i,
    output logic dev_req_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic err_o
);
    hsk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (tmo_i) begin
            r_d.err = 1'b1;
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (rd_s && wr_s) begin
                    r_d.err = 1'b1;
                end else if (!ack_s) begin
                    if (rd_s) begin
                        r_d.dev_req = 1'b1;
                        r_d.state   = ST_R_REQ;
                    end else if (wr_s) begin
                        r_d.xcvr_en = 1'b1;
                        r_d.state   = ST_W_EN;
                    end
                end
            end
            ST_R_REQ: begin
                if (ack_s) begin
                    r_d.xcvr_en = 1'b1;
                    r_d.state   = ST_R_DATA;
                end
            end
            ST_R_DATA: begin
                r_d.bus_ack = 1'b1;
                r_d.state   = ST_R_ACK;
            end
            ST_R_ACK: begin
                if (!rd_s) begin
                    r_d.xcvr_en = 1'b0;
                    r_d.state   = ST_R_REL;
                end
            end
            ST_R_REL: begin
                r_d.bus_ack = 1'b0;
                r_d.dev_req = 1'b0;
                r_d.state   = ST_IDLE;
            end
            ST_W_EN: begin
                r_d.dev_req = 1'b1;
                r_d.state   = ST_W_REQ;
            end
            ST_W_REQ: begin
                if (ack_s) begin
                    r_d.xcvr_en = 1'b0;
                    r_d.state   = ST_W_DROP;
                end
            end
            ST_W_DROP: begin
                r_d.bus_ack = 1'b1;
                r_d.dev_req = 1'b0;
                r_d.state   = ST_W_ACK;
            end
            ST_W_ACK: begin
                if (!wr_s) begin
                    r_d.bus_ack = 1'b0;
                    r_d.state   = ST_IDLE;
                end
            end
            default: r_d = HSK_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= HSK_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign dev_req_o = r_q.dev_req;
    assign xcvr_en_o = r_q.xcvr_en;
    assign bus_ack_o = r_q.bus_ack;
    assign err_o     = r_q.err;

    AST_ACK_AFTER_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.bus_ack) |-> $past(ack_s)); // R2

    AST_XCVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.xcvr_en) |-> ($past(ack_s) || $past(wr_s))); // R3

    AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && ack_s) |=> (r_q.state == ST_IDLE)); // R5

    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && rd_s && wr_s) |=> (r_q.state == ST_IDLE && r_q.err)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err); // R6

    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.xcvr_en) && r_q.bus_ack |=> (!r_q.bus_ack && !r_q.dev_req)); // R8

endmodule

// File: rtl/bus_slave_hsk.sv
module bus_slave_hsk #(
    parameter int unsigned TIMEOUT_CYC = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic dev_ack,
    output logic dev_req,
    output logic xcvr_en,
    output logic bus_ack,
    output logic proto_err
);
    localparam int unsigned NIN = 3;

    logic [NIN-1:0] in_s;
    logic           tmo;

    hsk_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dev_ack, wr_stb, rd_stb}),
        .sync_o  (in_s)
    );

    hsk_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_i   (dev_req != in_s[2]),
        .expire_o (tmo)
    );

    hsk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_s      (in_s[0]),
        .wr_s      (in_s[1]),
        .ack_s     (in_s[2]),
        .tmo_i     (tmo),
        .dev_req_o (dev_req),
        .xcvr_en_o (xcvr_en),
        .bus_ack_o (bus_ack),
        .err_o     (proto_err)
    );

endmodule

// File: tb/bus_slave_hsk_tb.sv
module bus_slave_hsk_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 1'b0, wr_stb = 1'b0, dev_ack = 1'b0;
    logic dev_req, xcvr_en, bus_ack, proto_err;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bus_slave_hsk u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .dev_ack(dev_ack), .dev_req(dev_req), .xcvr_en(xcvr_en),
        .bus_ack(bus_ack), .proto_err(proto_err)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rd_stb = 0; wr_stb = 0; dev_ack = 0;
        rst_n = 0;
        step(2);
        rst_n = 1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "dev_req", dev_req, 1'b0);
        chk("R1", "xcvr_en", xcvr_en, 1'b0);
        chk("R1", "bus_ack", bus_ack, 1'b0);
        chk("R1", "proto_err", proto_err, 1'b0);
    endtask

    task automatic t_read();
        do_reset();
        rd_stb = 1;
        step(2);
        chk("R4", "dev_req before 3rd edge", dev_req, 1'b0);
        step(1);
        chk("R2", "dev_req up", dev_req, 1'b1);
        chk("R2", "xcvr_en still low", xcvr_en, 1'b0);
        dev_ack = 1;
        step(3);
        chk("R2", "xcvr_en up", xcvr_en, 1'b1);
        chk("R2", "bus_ack not yet", bus_ack, 1'b0);
        step(1);
        chk("R2", "bus_ack up", bus_ack, 1'b1);
        rd_stb = 0;
        step(3);
        chk("R2", "xcvr_en down", xcvr_en, 1'b0);
        chk("R2", "bus_ack held", bus_ack, 1'b1);
        step(1);
        chk("R8", "bus_ack down with dev_ack high", bus_ack, 1'b0);
        chk("R2", "dev_req down", dev_req, 1'b0);
        rd_stb = 1;
        step(6);
        chk("R5", "no new request while ack high", dev_req, 1'b0);
        dev_ack = 0;
        step(3);
        chk("R5", "request after ack low", dev_req, 1'b1);
        chk("R6", "no error", proto_err, 1'b0);
    endtask

    task automatic t_write();
        do_reset();
        wr_stb = 1;
        step(3);
        chk("R3", "xcvr_en up", xcvr_en, 1'b1);
        chk("R3", "dev_req not yet", dev_req, 1'b0);
        step(1);
        chk("R3", "dev_req up", dev_req, 1'b1);
        dev_ack = 1;
        step(3);
        chk("R3", "xcvr_en down", xcvr_en, 1'b0);
        chk("R3", "bus_ack not yet", bus_ack, 1'b0);
        chk("R3", "dev_req held", dev_req, 1'b1);
        step(1);
        chk("R3", "bus_ack up", bus_ack, 1'b1);
        chk("R3", "dev_req down", dev_req, 1'b0);
        wr_stb = 0;
        step(2);
        chk("R4", "bus_ack before 3rd edge", bus_ack, 1'b1);
        step(1);
        chk("R3", "bus_ack down", bus_ack, 1'b0);
        dev_ack = 0;
        step(3);
        chk("R3", "idle outputs", dev_req | xcvr_en | bus_ack, 1'b0);
    endtask

    task automatic t_both();
        do_reset();
        rd_stb = 1; wr_stb = 1;
        step(5);
        chk("R6", "no output", dev_req | xcvr_en | bus_ack, 1'b0);
        chk("R6", "error set", proto_err, 1'b1);
        rd_stb = 0; wr_stb = 0;
        step(5);
        chk("R6", "error sticky", proto_err, 1'b1);
    endtask

    task automatic t_timeout();
        do_reset();
        rd_stb = 1;
        step(3);
        chk("R7", "dev_req up", dev_req, 1'b1);
        step(1000);
        chk("R7", "no error before limit", proto_err, 1'b0);
        step(40);
        chk("R7", "error after limit", proto_err, 1'b1);
        dev_ack = 1;
        step(3);
        chk("R7", "late ack advances", xcvr_en, 1'b1);
    endtask

    initial begin
        t_reset();
        t_read();
        t_write();
        t_both();
        t_timeout();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule